// File: doc/BRIEF.md
# LCD pixel clock generator

This block derives a display pixel clock from one of two source clocks. Both sources are modelled as synchronous enables on the system clock, so every output changes on a system clock edge. A selector and a gate pick the source. A fractional divider then turns source pulses into module-clock edges, with an integer divisor plus an optional numerator/denominator fraction. Each edge toggles the module clock, so one module-clock period spans two edges. A phase state machine then builds the pixel clock from those edges. Each half of a pixel period lasts N+1 module-clock edges, or a single edge in bypass, which makes the pixel clock either the module clock divided by N+1 or the module clock itself.

All settings sit in one 32-bit control word with a write strobe. A write is held pending and reaches the active copy only at the start of a pixel period, or at once while the clock rests, so a period never mixes two settings. The phase machine has three states. REST drives the programmed idle level. LEAD drives the programmed first-half level. TRAIL drives its inverse. Its transitions are `start` (REST to LEAD on a module edge while running), `half` (LEAD to TRAIL after the half length), `wrap` (TRAIL to LEAD when running continues, which also loads pending settings), `finish` (TRAIL to REST when the run request has dropped) and `stop` (LEAD or TRAIL to REST when the active settings leave no source). A one-cycle tick marks every entry into LEAD, and data-path logic launches pixels on it.

Top module: `lcd_pclk_gen`

## Requirements
- R1: After reset the active control word is 0x0000_0843 (gate off, no source). The pixel clock is low and no tick appears even while run is high.
- R2: Bits 30:29 select the source: 1 selects `src_a_en`, 2 selects `src_b_en`, and 0 or 3 select nothing, so no module edge and no tick appear.
- R3: With bit 31 at 0 no module edge is produced. Once such settings are active the pixel clock returns to REST, holds the idle level and emits no tick.
- R4: Bits 16:9 hold the integer divisor D. A module edge follows every D source pulses, a value of 0 means 256, and a value of 1 passes every source pulse on as an edge.
- R5: Bits 22:17 hold the numerator b and bits 28:23 the denominator a. When 0 < b < a, any a consecutive module-edge intervals contain exactly b that are one source pulse longer. Any other b/a leaves the divisor a plain integer.
- R6: Bits 5:0 hold N and bit 6 is bypass. A pixel period lasts 2*(N+1) module edges when bypass is 0, and 2 edges when bypass is 1.
- R7: Bit 8 gives the pixel clock level for the first half of every period, and the second half has the inverse level. Each half lasts H*D system cycles with a continuous source, where H is the half length in edges.
- R8: Bit 7 gives the level of the pixel clock in REST.
- R9: `pix_tick` is high for exactly one cycle, the first cycle of each pixel period, and the pixel clock shows the first-half level in that cycle.
- R10: A written control word takes effect at the next period start while the clock runs, and on the next cycle while in REST.
- R11: When run drops, the period in progress completes with both halves at full length. The clock then rests and no further tick appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_en | input | 1 | Pulse of source clock A |
| src_b_en | input | 1 | Pulse of source clock B |
| run | input | 1 | Request to keep producing pixel periods |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| pclk_out | output | 1 | Pixel clock level |
| pix_tick | output | 1 | One-cycle marker of each period start |

## Verification
The embedded properties check on every cycle that a tick lasts one cycle and always shows the first-half level, that the pixel clock holds steady inside a half, that no tick follows once the source is stopped, that the divider count stays bounded, and that the active settings change only in REST or at a period start. Period lengths under integer and fractional division, the source selection, the exact half durations and the completion of a period after run drops relate counts over many cycles, so only the bench's measured scenarios can show them.

// File: rtl/lcd_pclk_pkg.sv
package lcd_pclk_pkg;

    localparam int CFG_W  = 32;
    localparam int DIV_W  = 8;
    localparam int FRAC_W = 6;
    localparam int N_W    = 6;

    // Field order from MSB down to LSB follows the control word layout.
    typedef struct packed {
        logic              gate;
        logic [1:0]        src_sel;
        logic [FRAC_W-1:0] den;
        logic [FRAC_W-1:0] num;
        logic [DIV_W-1:0]  div_int;
        logic              first_hi;
        logic              idle_hi;
        logic              bypass;
        logic [N_W-1:0]    half_n;
    } pclk_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0843;

    localparam logic [1:0] SEL_SRC_A = 2'd1;
    localparam logic [1:0] SEL_SRC_B = 2'd2;

    typedef enum logic [1:0] {
        PX_REST  = 2'd0,
        PX_LEAD  = 2'd1,
        PX_TRAIL = 2'd2
    } px_state_t;

endpackage

// File: rtl/pclk_cfg_hold.sv
module pclk_cfg_hold
    import lcd_pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             apply,
    output pclk_cfg_t        act
);

    pclk_cfg_t pend;
    pclk_cfg_t pend_nxt;

    always_comb begin
        pend_nxt = we ? pclk_cfg_t'(wdata) : pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= pclk_cfg_t'(CFG_RESET);
            act  <= pclk_cfg_t'(CFG_RESET);
        end else begin
            pend <= pend_nxt;
            if (apply) begin
                act <= pend_nxt;
            end
        end
    end

endmodule

// File: rtl/pclk_frac_div.sv
module pclk_frac_div #(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_pulse,
    input  logic              active,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] num,
    input  logic [FRAC_W-1:0] den,
    output logic              edge_en
);

    localparam int CW = DIV_W + 2;
    localparam int AW = FRAC_W + 1;
    localparam logic [CW-1:0] FULL_SPAN = CW'(2 ** DIV_W);

    logic [CW-1:0] cnt;
    logic [CW-1:0] base;
    logic [CW-1:0] span;
    logic          stretch;
    logic [AW-1:0] acc;
    logic [AW-1:0] acc_sum;
    logic          last;
    logic          frac_on;

    always_comb begin
        frac_on = (num != '0) && (den != '0) && (num < den);
        base    = (div_int == '0) ? FULL_SPAN : CW'(div_int);
        span    = base + CW'(stretch);
        last    = (cnt + CW'(1)) >= span;
        edge_en = active && src_pulse && last;
        acc_sum = acc + AW'(num);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
        end else if (!active) begin
            cnt     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
        end else if (src_pulse) begin
            if (last) begin
                cnt <= '0;
                if (frac_on) begin
                    if (acc_sum >= AW'(den)) begin
                        acc     <= acc_sum - AW'(den);
                        stretch <= 1'b1;
                    end else begin
                        acc     <= acc_sum;
                        stretch <= 1'b0;
                    end
                end else begin
                    acc     <= '0;
                    stretch <= 1'b0;
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R4: the pulse counter never runs past the largest divisor plus stretch
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_SPAN);

endmodule

// File: rtl/pclk_phase_fsm.sv
module pclk_phase_fsm
    import lcd_pclk_pkg::*;
#(
    parameter int HN_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_en,
    input  logic            clk_on,
    input  logic            run,
    input  logic            bypass,
    input  logic [HN_W-1:0] half_n,
    input  logic            first_hi,
    input  logic            idle_hi,
    output logic            pclk,
    output logic            tick,
    output logic            apply,
    output logic            at_rest
);

    localparam int HW = HN_W + 1;

    px_state_t     state;
    px_state_t     state_nxt;
    logic [HW-1:0] hc;
    logic [HW-1:0] half_len;
    logic          hc_last;
    logic          go_lead;
    logic          wrap;

    always_comb begin
        half_len  = bypass ? HW'(1) : (HW'(half_n) + HW'(1));
        hc_last   = (hc + HW'(1)) >= half_len;
        state_nxt = state;
        go_lead   = 1'b0;
        wrap      = 1'b0;
        unique case (state)
            PX_REST: begin
                if (clk_on && run && edge_en) begin
                    state_nxt = PX_LEAD;
                    go_lead   = 1'b1;
                end
            end
            PX_LEAD: begin
                if (!clk_on) begin
                    state_nxt = PX_REST;
                end else if (edge_en && hc_last) begin
                    state_nxt = PX_TRAIL;
                end
            end
            PX_TRAIL: begin
                if (!clk_on) begin
                    state_nxt = PX_REST;
                end else if (edge_en && hc_last) begin
                    if (run) begin
                        state_nxt = PX_LEAD;
                        go_lead   = 1'b1;
                        wrap      = 1'b1;
                    end else begin
                        state_nxt = PX_REST;
                    end
                end
            end
            default: state_nxt = PX_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PX_REST;
            hc    <= '0;
            tick  <= 1'b0;
        end else begin
            state <= state_nxt;
            tick  <= go_lead;
            if (state_nxt != state) begin
                hc <= '0;
            end else if (edge_en) begin
                hc <= hc + HW'(1);
            end
        end
    end

    always_comb begin
        at_rest = (state == PX_REST);
        apply   = at_rest || wrap;
        unique case (state)
            PX_LEAD:  pclk = first_hi;
            PX_TRAIL: pclk = ~first_hi;
            default:  pclk = idle_hi;
        endcase
    end

    // R9: a tick never lasts longer than one cycle
    assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R9 / R7: the tick cycle shows the first-half level
    assert_tick_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (pclk == first_hi));

    // R7: within the first half the level holds steady
    assert_half_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PX_LEAD && $past(state) == PX_LEAD) |-> $stable(pclk));

    // R3: a stopped source never produces a tick
    assert_no_tick_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_on |=> !tick);

endmodule

// File: rtl/lcd_pclk_gen.sv
module lcd_pclk_gen
    import lcd_pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_a_en,
    input  logic             src_b_en,
    input  logic             run,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             pclk_out,
    output logic             pix_tick
);

    pclk_cfg_t act;
    logic      apply;
    logic      at_rest;
    logic      src_valid;
    logic      clk_on;
    logic      src_pulse;
    logic      edge_en;

    pclk_cfg_hold u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .apply (apply),
        .act   (act)
    );

    always_comb begin
        src_valid = (act.src_sel == SEL_SRC_A) || (act.src_sel == SEL_SRC_B);
        clk_on    = act.gate && src_valid;
        unique case (act.src_sel)
            SEL_SRC_A: src_pulse = clk_on && src_a_en;
            SEL_SRC_B: src_pulse = clk_on && src_b_en;
            default:   src_pulse = 1'b0;
        endcase
    end

    pclk_frac_div #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .active    (clk_on),
        .div_int   (act.div_int),
        .num       (act.num),
        .den       (act.den),
        .edge_en   (edge_en)
    );

    pclk_phase_fsm #(
        .HN_W (N_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_en  (edge_en),
        .clk_on   (clk_on),
        .run      (run),
        .bypass   (act.bypass),
        .half_n   (act.half_n),
        .first_hi (act.first_hi),
        .idle_hi  (act.idle_hi),
        .pclk     (pclk_out),
        .tick     (pix_tick),
        .apply    (apply),
        .at_rest  (at_rest)
    );

    // R10: active settings move only while resting or at a period start
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> (pix_tick || $past(at_rest)));

endmodule

// File: tb/tb_lcd_pclk_gen.sv
module tb_lcd_pclk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_a_en = 1'b1;
    logic        src_b_en = 1'b0;
    logic        run = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        pclk_out;
    logic        pix_tick;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  b_toggle = 1'b0;

    always #4 clk = ~clk;

    lcd_pclk_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a_en  (src_a_en),
        .src_b_en  (src_b_en),
        .run       (run),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .pclk_out  (pclk_out),
        .pix_tick  (pix_tick)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (b_toggle) src_b_en = ~src_b_en;
        end
    end

    function automatic logic [31:0] mk_cfg(input bit gate, input int sel, input int den,
                                           input int num, input int dv, input bit first,
                                           input bit idle, input bit byp, input int n);
        return {gate, 2'(sel), 6'(den), 6'(num), 8'(dv), first, idle, byp, 6'(n)};
    endfunction

    function automatic int half_edges(input bit byp, input int n);
        return byp ? 1 : n + 1;
    endfunction

    // Cycles for k pixel periods with a source pulse every cycle.
    function automatic int exp_cycles(input int dv, input int n, input bit byp,
                                      input int num, input int den, input int k);
        int d, edges, tot;
        d     = (dv == 0) ? 256 : dv;
        edges = 2 * half_edges(byp, n) * k;
        tot   = edges * d;
        if (num != 0 && den != 0 && num < den) tot += (edges / den) * num;
        return tot;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Counts negedges until a tick is seen (the tick cycle included).
    task automatic wait_tick(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!pix_tick && cyc < 4000);
    endtask

    task automatic count_ticks(input int cycles, output int ticks);
        ticks = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (pix_tick) ticks++;
        end
    endtask

    task automatic measure(input int k, output int total);
        int c;
        wait_tick(c);
        wait_tick(c);
        total = 0;
        for (int i = 0; i < k; i++) begin
            wait_tick(c);
            total += c;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int t, c, hi, k;
        int dv, n, num, den;
        bit byp, first, idle;
        void'($urandom(32'd20240611));

        // R1: reset state
        run = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 pclk in reset", pclk_out, 0);
        rst_n = 1'b1;
        count_ticks(60, t);
        check("R1 no tick after reset", t, 0);
        check("R1 pclk low after reset", pclk_out, 0);

        // R4/R7: integer divide, D=2, N=1
        write_cfg(mk_cfg(1, 1, 0, 0, 2, 1, 0, 0, 1));
        measure(1, t);
        check("R4 period D=2 N=1", t, 8);
        hi = 1;
        repeat (20) begin
            @(negedge clk);
            if (pclk_out) hi++;
            else break;
        end
        check("R7 first-half length", hi, 4);

        // R4: divisor 0 means 256, bypass
        write_cfg(mk_cfg(1, 1, 0, 0, 0, 1, 0, 1, 0));
        measure(1, t);
        check("R4 divisor zero as 256", t, 512);

        // R6/R4: divisor 1 passes through, bypass gives two edges per period
        write_cfg(mk_cfg(1, 1, 0, 0, 1, 0, 0, 1, 5));
        measure(2, t);
        check("R6 bypass D=1 period", t, 4);

        // R5: directed fraction 1/3
        write_cfg(mk_cfg(1, 1, 3, 1, 2, 1, 0, 1, 0));
        measure(3, t);
        check("R5 fraction 1/3", t, exp_cycles(2, 0, 1, 1, 3, 3));

        // R5/R6/R9: randomised settings
        for (int it = 0; it < 8; it++) begin
            dv    = 1 + int'($urandom_range(3));
            n     = int'($urandom_range(4));
            byp   = 1'($urandom_range(1));
            first = 1'($urandom_range(1));
            idle  = 1'($urandom_range(1));
            den   = int'($urandom_range(5));
            num   = int'($urandom_range(5));
            k     = (num != 0 && den != 0 && num < den) ? den : 1;
            write_cfg(mk_cfg(1, 1, den, num, dv, first, idle, byp, n));
            measure(k, t);
            check("R5 R6 random period", t, exp_cycles(dv, n, byp, num, den, k));
            check("R9 tick first level", pclk_out, int'(first));
            @(negedge clk);
            check("R9 tick one cycle", pix_tick, 0);
        end

        // R10: change at boundary while running
        write_cfg(mk_cfg(1, 1, 0, 0, 2, 1, 0, 0, 2));
        wait_tick(c);
        wait_tick(c);
        write_cfg(mk_cfg(1, 1, 0, 0, 2, 1, 0, 0, 0));
        wait_tick(c);
        check("R10 old period kept", c + 2, 12);
        wait_tick(c);
        check("R10 new period at boundary", c, 4);

        // R11: run drops, period completes
        write_cfg(mk_cfg(1, 1, 0, 0, 2, 1, 0, 0, 1));
        wait_tick(c);
        wait_tick(c);
        run = 1'b0;
        hi = 1;
        t = 0;
        repeat (100) begin
            @(negedge clk);
            if (pclk_out) hi++;
            if (pix_tick) t++;
        end
        check("R11 full first half", hi, 4);
        check("R11 no tick after run low", t, 0);
        check("R8 idle low", pclk_out, 0);

        // R10/R8: immediate apply while resting
        write_cfg(mk_cfg(1, 1, 0, 0, 2, 1, 1, 0, 1));
        @(negedge clk);
        check("R10 R8 idle high applied", pclk_out, 1);

        // R3: gate off stops the clock at idle level
        run = 1'b1;
        write_cfg(mk_cfg(1, 1, 0, 0, 2, 0, 1, 0, 1));
        wait_tick(c);
        wait_tick(c);
        write_cfg(mk_cfg(0, 1, 0, 0, 2, 0, 1, 0, 1));
        wait_tick(c);
        count_ticks(100, t);
        check("R3 no tick gate off", t, 0);
        check("R3 idle level held", pclk_out, 1);

        // R2: selections 3 and 0 give nothing
        write_cfg(mk_cfg(1, 3, 0, 0, 1, 1, 0, 1, 0));
        count_ticks(60, t);
        check("R2 select 3 no tick", t, 0);
        write_cfg(mk_cfg(1, 0, 0, 0, 1, 1, 0, 1, 0));
        count_ticks(60, t);
        check("R2 select 0 no tick", t, 0);

        // R2: source B at half rate
        b_toggle = 1'b1;
        write_cfg(mk_cfg(1, 2, 0, 0, 2, 1, 0, 0, 1));
        measure(2, t);
        check("R2 source B period", t, 2 * 16);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule